// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Read

This block is a 16-bit up-counter that never stops. A fixed divide-by-four prescaler drives it from the bus clock, so one full lap of the count takes 262,144 bus cycles. An 8-bit processor reads the count as two bytes over a simple byte-wide register bus. A read of the high byte freezes a copy of the low byte. The two halves of a read pair therefore always come from the same instant, even when the low byte has moved on by the time it is fetched.

Each time the counter wraps from all ones to zero, a sticky overflow flag is set. An interrupt request follows the flag when software has enabled it. Software clears the flag with a two-step sequence: a read of the status register while the flag is set, then a read of the counter low byte. Bus reads complete in the cycle the strobe is high. Their side effects (latch capture, latch release, flag arming and clearing) take place at the clock edge that ends that cycle.

Top module: `frt_core`

## Requirements
- R1: The counter increases by exactly one every fourth bus clock. The prescaler phase starts at zero after reset, so the first increment happens on the fourth rising edge after reset is released.
- R2: After reset the count is 0xFFFC, the overflow flag and the interrupt enable are 0, the irq output is low, and the low-byte hold latch is transparent.
- R3: Offsets 0x18 (count high) and 0x19 (count low) are read-only. A write to either leaves the count unchanged.
- R4: When no high-byte read is pending, a read at 0x19 returns the live low byte of the count.
- R5: A read at 0x18 returns the live high byte and captures the live low byte into the hold latch. Later reads at 0x19 return the captured byte until one such read completes, and that read makes the latch transparent again.
- R6: A read at 0x18 while the latch already holds a value does not reload it. The byte from the first high read is kept.
- R7: When the count wraps from 0xFFFF to 0x0000, the overflow flag is set. The flag reads as bit 5 of the status register at offset 0x13, and all other status bits read 0.
- R8: The flag clears only when a read at 0x13 sees it set and a later read at 0x19 follows. A read at 0x19 that was not armed this way leaves the flag set. A wrap on the same edge as the clearing read keeps the flag set.
- R9: The interrupt enable is bit 5 of the control register at offset 0x12. That bit can be written and read back, and the other control bits read 0. irq is high exactly while both the flag and the enable are 1.
- R10: Reads at any offset other than 0x12, 0x13, 0x18 and 0x19 return 0x00. The counter keeps counting while the latch is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
On every cycle, the assertions check the following: the counter's single-step advance, no movement of the count between ticks, the spacing of the ticks, that a held byte stays unchanged under repeated high reads, that a wrap sets the flag, and that the flag can only fall after an armed low read. The bench's scenarios are what show the values software actually reads back. These include the reset values, the byte snapshot across a delay, write immunity of the count registers, zeros at unmapped offsets, and the complete arm-then-clear sequence, all at the first wrap after reset. The case where a wrap and a clearing read land on the same edge is covered only by the flag assertion and the bench's model, because the second wrap lies a full period away.

// File: rtl/frt_pkg.sv
package frt_pkg;
    localparam int unsigned BUS_W = 8;

    localparam logic [7:0] OFF_CTRL  = 8'h12;
    localparam logic [7:0] OFF_STAT  = 8'h13;
    localparam logic [7:0] OFF_CNT_H = 8'h18;
    localparam logic [7:0] OFF_CNT_L = 8'h19;

    localparam int unsigned FLAG_BIT = 5;

    typedef struct packed {
        logic ovf_ie;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic armed;
    } flag_t;
endpackage

// File: rtl/frt_prescale.sv
module frt_prescale #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST) st_d.phase = '0;
        else                    st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.phase == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick) else $error("tick too close"); // R1
        end
    endgenerate
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RST_VAL = 16'hFFFC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= RST_VAL;
        else        st_q     <= st_d;
    end

    assign count = st_q.cnt;
    assign wrap  = tick && (st_q.cnt == '1);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1)) else $error("bad step"); // R1
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)) else $error("count moved off tick"); // R3
endmodule

// File: rtl/frt_snap.sv
module frt_snap #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         rel,
    input  logic [W-1:0] live,
    output logic [W-1:0] lo_out
);
    typedef struct packed {
        logic         held;
        logic [W-1:0] val;
    } snap_t;

    snap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap && !st_q.held) begin
            st_d.held = 1'b1;
            st_d.val  = live;
        end
        if (rel) st_d.held = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_out = st_q.held ? st_q.val : live;

    AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !rel) |=> (st_q.held && $stable(st_q.val))) else $error("held byte changed"); // R6
endmodule

// File: rtl/frt_flag.sv
module frt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic stat_rd,
    input  logic lo_rd,
    output logic ovf
);
    import frt_pkg::*;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_rd && st_q.ovf) st_d.armed = 1'b1;
        if (lo_rd && st_q.armed) begin
            st_d.ovf   = 1'b0;
            st_d.armed = 1'b0;
        end
        if (wrap) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf = st_q.ovf;

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf) else $error("wrap lost"); // R7
    AST_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(lo_rd && st_q.armed)) else $error("flag cleared unarmed"); // R8
endmodule

// File: rtl/frt_core.sv
module frt_core
    import frt_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned PRE_DIV = 4,
    parameter logic [CNT_W-1:0] CNT_RST = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq
);
    localparam int unsigned HI_W = CNT_W - BUS_W;

    logic             tick, wrap, ovf;
    logic [CNT_W-1:0] count;
    logic [BUS_W-1:0] lo_byte;
    logic             sel_ctrl, sel_stat, sel_hi, sel_lo;
    ctrl_t            ctl_d, ctl_q;
    logic             unused_wbits;

    assign sel_ctrl = (bus_addr == OFF_CTRL);
    assign sel_stat = (bus_addr == OFF_STAT);
    assign sel_hi   = (bus_addr == OFF_CNT_H);
    assign sel_lo   = (bus_addr == OFF_CNT_L);
    assign unused_wbits = ^{bus_wdata[BUS_W-1:FLAG_BIT+1], bus_wdata[FLAG_BIT-1:0]};

    frt_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    frt_counter #(.W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .count(count),
        .wrap (wrap)
    );

    frt_snap #(.W(BUS_W)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (bus_rd && sel_hi),
        .rel   (bus_rd && sel_lo),
        .live  (count[BUS_W-1:0]),
        .lo_out(lo_byte)
    );

    frt_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .stat_rd(bus_rd && sel_stat),
        .lo_rd  (bus_rd && sel_lo),
        .ovf    (ovf)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr && sel_ctrl) ctl_d.ovf_ie = bus_wdata[FLAG_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)      bus_rdata[FLAG_BIT] = ctl_q.ovf_ie;
        else if (sel_stat) bus_rdata[FLAG_BIT] = ovf;
        else if (sel_hi)   bus_rdata = count[CNT_W-1 -: HI_W];
        else if (sel_lo)   bus_rdata = lo_byte;
    end

    assign irq = ovf && ctl_q.ovf_ie;

    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ovf) else $error("irq without flag"); // R9
endmodule

// File: tb/sim_frt_core.sv
module sim_frt_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    bit         m_held = 1'b0;
    logic [7:0] m_val  = 8'h00;

    always #5 clk = ~clk;

    frt_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) if (rst_n) edges = edges + 1;

    function automatic logic [15:0] model_cnt();
        return 16'(32'hFFFC + (edges / 4));
    endfunction

    // monitor: pops expected read data mid-cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard empty: actual %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s addr %02h: actual %02h expected %02h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [7:0] a, input string t, input bit use_exp = 1'b0,
                      input logic [7:0] given = 8'h00);
        logic [7:0] e;
        logic [15:0] c;
        @(posedge clk); #1;
        c = model_cnt();
        if (use_exp)           e = given;
        else if (a == 8'h18) begin
            e = c[15:8];
            if (!m_held) begin m_held = 1'b1; m_val = c[7:0]; end
        end else if (a == 8'h19) begin
            e = m_held ? m_val : c[7:0];
            m_held = 1'b0;
        end else e = 8'h00;
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq: actual %0b expected %0b", t, irq, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R2 reset state, read before the first wrap at edge 16
        rd(8'h13, "R2 status", 1'b1, 8'h00);
        rd(8'h12, "R2 ctrl", 1'b1, 8'h00);
        chk_irq(1'b0, "R2");
        rd(8'h19, "R2 R4 low after reset");
        wr(8'h12, 8'h20);
        rd(8'h12, "R9 enable readback", 1'b1, 8'h20);
        while (edges < 18) @(posedge clk);
        #1;
        chk_irq(1'b1, "R9 irq on flag");
        rd(8'h19, "R4 live low");
        rd(8'h13, "R7 R8 flag kept by unarmed low read", 1'b1, 8'h20);
        rd(8'h19, "R8 clearing low read");
        rd(8'h13, "R8 flag cleared", 1'b1, 8'h00);
        #1;
        chk_irq(1'b0, "R8 R9 irq drops");
        // R1 / R4 at different phases
        idle(3); rd(8'h19, "R1 phase a");
        idle(6); rd(8'h19, "R1 phase b");
        idle(1); rd(8'h19, "R1 phase c");
        // R5 snapshot
        rd(8'h18, "R5 high");
        idle(13);
        rd(8'h19, "R5 held low");
        rd(8'h19, "R5 released low");
        // R6 repeated high reads
        rd(8'h18, "R6 first high");
        idle(9);
        rd(8'h18, "R6 second high");
        idle(7);
        rd(8'h19, "R6 R10 held from first");
        // R3 writes ignored
        wr(8'h18, 8'h55);
        wr(8'h19, 8'hAA);
        rd(8'h19, "R3 count after writes");
        rd(8'h18, "R3 high after writes");
        rd(8'h19, "R3 low pair");
        // R10 unmapped
        rd(8'h00, "R10 unmapped 00");
        rd(8'h15, "R10 unmapped 15");
        rd(8'hFF, "R10 unmapped FF");
        // R9 other ctrl bits read 0
        wr(8'h12, 8'hDF);
        rd(8'h12, "R9 ctrl only bit5", 1'b1, 8'h00);
        idle(2);
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                #2_000_000;
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule